// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a RISC integer data path. One operand word, a three-bit shift kind, an eight-bit shift count and the current carry flag go in. The shifted word and the carry produced by the shift come out. Five shift kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry flag. Every count from 0 to 255 has a defined result and a defined carry. This includes a zero count and counts at or above the word width.

The shift itself is purely combinational. An optional output stage, selected by a parameter, captures the result and carry on a valid strobe and presents them one cycle later. Fetching operands, adjusting program-counter reads and writing flags back to a status register all belong to the surrounding data path.

Top module: `bsh_unit`

## Requirements
- R1: Kind code 0 is logical left. For a count n from 1 to 32, the result is the operand shifted left by n with zeros filled in, and the carry is operand bit 32-n. A count of exactly 32 therefore gives zero with carry equal to operand bit 0.
- R2: Kind code 1 is logical right. For a count n from 1 to 32, the result is the operand shifted right by n with zeros filled in, and the carry is operand bit n-1.
- R3: Kind code 2 is arithmetic right. For a count n from 1 to 32, vacated positions take the operand's bit 31, and the carry is operand bit n-1.
- R4: Kind code 3 is rotate right. For a nonzero count, the operand rotates right by the count modulo 32, and the carry equals bit 31 of the result. A count of 32 therefore returns the operand unchanged, with carry equal to its bit 31.
- R5: Kind code 4 is rotate through carry. The result is the incoming carry in bit 31 above operand bits 31..1, and the carry is operand bit 0. The count has no effect.
- R6: For kind codes 0 to 3 with a count of zero, the result equals the operand and the carry equals the incoming carry.
- R7: For kind codes 0 and 1 with a count above 32, both the result and the carry are zero.
- R8: For kind code 2 with a count above 32, every result bit and the carry equal operand bit 31.
- R9: Kind codes 5, 6 and 7 return the operand unchanged, with the carry equal to the incoming carry.
- R10: With the output stage enabled, out_valid is high exactly in the cycle after a cycle with in_valid high. The result and carry are those computed from the inputs present at that strobe.
- R11: With the output stage enabled, a cycle with in_valid low leaves result and carry_out unchanged, whatever the other inputs do.
- R12: After reset, out_valid, result and carry_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe that captures a new shift |
| operand | input | W (32) | Word to be shifted |
| shift_type | input | 3 | Shift kind code (0 left, 1 right, 2 arithmetic, 3 rotate, 4 rotate through carry) |
| shift_amt | input | AMT_W (8) | Shift count, 0 to 255 |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | W (32) | Shifted word |
| carry_out | output | 1 | Carry produced by the shift |

## Verification
The bench builds the block with W=32, AMT_W=8 and the output stage enabled (REG_OUT=1). The full 0..255 count range is reachable, so the zero, exact-32, in-range and above-32 classes of every kind can each be driven directly. Enabling the stage makes the one-cycle latency and the hold behaviour between strobes observable at the ports. The reference model shifts one bit position per loop iteration, so the carry for any count falls out of the iteration rather than out of a bit-index formula.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

endpackage

// File: rtl/bsh_amt_decode.sv
module bsh_amt_decode #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [AMT_W-1:0]         amt,
  output logic                     amt_zero,
  output logic                     amt_over,
  output logic [$clog2(W)-1:0]     rot_dist
);
  localparam int DW = $clog2(W);

  // Count classes: zero, 1..W, above W. W is assumed a power of two.
  assign amt_zero = (amt == '0);
  assign amt_over = ({1'b0, amt} > (AMT_W+1)'(W));
  assign rot_dist = amt[DW-1:0];

endmodule

// File: rtl/bsh_core.sv
module bsh_core
  import bsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]          op,
  input  logic [2:0]            kind,
  input  logic [AMT_W-1:0]      amt,
  input  logic                  amt_zero,
  input  logic                  amt_over,
  input  logic [$clog2(W)-1:0]  rot_dist,
  input  logic                  cin,
  output logic [W-1:0]          res,
  output logic                  cout
);
  localparam int DW = $clog2(W);

  // Each returns {carry, result}; valid for counts 1..W.
  function automatic logic [W:0] f_lsl(input logic [W-1:0] v, input logic [AMT_W-1:0] n);
    logic [2*W-1:0] t;
    t = {{W{1'b0}}, v} << n;
    return {t[W], t[W-1:0]};
  endfunction

  function automatic logic [W:0] f_lsr(input logic [W-1:0] v, input logic [AMT_W-1:0] n);
    logic [2*W-1:0] t;
    t = {v, {W{1'b0}}} >> n;
    return {t[W-1], t[2*W-1:W]};
  endfunction

  function automatic logic [W:0] f_asr(input logic [W-1:0] v, input logic [AMT_W-1:0] n);
    logic signed [2*W-1:0] t;
    t = $signed({v, {W{1'b0}}}) >>> n;
    return {t[W-1], t[2*W-1:W]};
  endfunction

  function automatic logic [W:0] f_ror(input logic [W-1:0] v, input logic [DW-1:0] d);
    logic [W-1:0] r;
    r = (v >> d) | (v << (W - int'(d)));
    return {r[W-1], r};
  endfunction

  logic [W:0] lsl_v, lsr_v, asr_v, ror_v;

  assign lsl_v = f_lsl(op, amt);
  assign lsr_v = f_lsr(op, amt);
  assign asr_v = f_asr(op, amt);
  assign ror_v = f_ror(op, rot_dist);

  always_comb begin
    res  = op;
    cout = cin;
    unique case (kind)
      SK_LSL: begin
        if (amt_over)       {cout, res} = '0;
        else if (!amt_zero) {cout, res} = lsl_v;
      end
      SK_LSR: begin
        if (amt_over)       {cout, res} = '0;
        else if (!amt_zero) {cout, res} = lsr_v;
      end
      SK_ASR: begin
        if (amt_over)       {cout, res} = {(W+1){op[W-1]}};
        else if (!amt_zero) {cout, res} = asr_v;
      end
      SK_ROR: begin
        if (!amt_zero)      {cout, res} = ror_v;
      end
      SK_RRX: begin
        res  = {cin, op[W-1:1]};
        cout = op[0];
      end
      default: begin
        res  = op;
        cout = cin;
      end
    endcase
  end

endmodule

// File: rtl/bsh_out_stage.sv
module bsh_out_stage #(
  parameter int W   = 32,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] res_i,
  input  logic         c_i,
  output logic         vld_o,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_o <= 1'b0;
          res_o <= '0;
          c_o   <= 1'b0;
        end else begin
          vld_o <= vld_i;
          if (vld_i) begin
            res_o <= res_i;
            c_o   <= c_i;
          end
        end
      end
    end else begin : g_comb
      assign vld_o = vld_i;
      assign res_o = res_i;
      assign c_o   = c_i;
    end
  endgenerate

endmodule

// File: rtl/bsh_unit.sv
module bsh_unit #(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     operand,
  input  logic [2:0]       shift_type,
  input  logic [AMT_W-1:0] shift_amt,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             carry_out
);
  localparam int DW = $clog2(W);

  // Named internal events for the checker.
  logic          amt_zero;
  logic          amt_over;
  logic [DW-1:0] rot_dist;
  logic [W-1:0]  core_res;
  logic          core_cout;

  bsh_amt_decode #(.W(W), .AMT_W(AMT_W)) u_dec (
    .amt      (shift_amt),
    .amt_zero (amt_zero),
    .amt_over (amt_over),
    .rot_dist (rot_dist)
  );

  bsh_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .op       (operand),
    .kind     (shift_type),
    .amt      (shift_amt),
    .amt_zero (amt_zero),
    .amt_over (amt_over),
    .rot_dist (rot_dist),
    .cin      (carry_in),
    .res      (core_res),
    .cout     (core_cout)
  );

  bsh_out_stage #(.W(W), .REG(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_valid),
    .res_i (core_res),
    .c_i   (core_cout),
    .vld_o (out_valid),
    .res_o (result),
    .c_o   (carry_out)
  );

endmodule

// File: rtl/bsh_unit_chk.sv
module bsh_unit_chk #(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [W-1:0]     operand,
  input logic [2:0]       shift_type,
  input logic [AMT_W-1:0] shift_amt,
  input logic             carry_in,
  input logic             amt_zero,
  input logic             amt_over,
  input logic             out_valid,
  input logic [W-1:0]     result,
  input logic             carry_out
);
  generate
    if (REG_OUT) begin : g_chk
      a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(carry_out)));
      a_r5_rrx: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_type == 3'd4) |=>
          (result == {$past(carry_in), $past(operand[W-1:1])} && carry_out == $past(operand[0])));
      a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_type < 3'd4 && amt_zero) |=>
          (result == $past(operand) && carry_out == $past(carry_in)));
      a_r7_logical_over: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_type < 3'd2 && amt_over) |=>
          (result == '0 && !carry_out));
      a_r8_arith_over: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_type == 3'd2 && amt_over) |=>
          (result == {W{$past(operand[W-1])}} && carry_out == $past(operand[W-1])));
      a_r4_rotate_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_type == 3'd3 && shift_amt != '0) |=>
          (carry_out == result[W-1]));
      a_r9_unused_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_type > 3'd4) |=>
          (result == $past(operand) && carry_out == $past(carry_in)));
    end
  endgenerate

endmodule

bind bsh_unit bsh_unit_chk #(.W(W), .AMT_W(AMT_W), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .operand    (operand),
  .shift_type (shift_type),
  .shift_amt  (shift_amt),
  .carry_in   (carry_in),
  .amt_zero   (amt_zero),
  .amt_over   (amt_over),
  .out_valid  (out_valid),
  .result     (result),
  .carry_out  (carry_out)
);

// File: tb/bsh_unit_tb.sv
module bsh_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [2:0]  shift_type = '0;
  logic [7:0]  shift_amt = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] last_r;
  logic        last_c;

  always #5ns clk = ~clk;

  bsh_unit #(.W(32), .AMT_W(8), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .shift_type(shift_type), .shift_amt(shift_amt), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out)
  );

  // Behavioural model: move one bit per iteration.
  task automatic model(input logic [31:0] op, input logic [2:0] ty, input logic [7:0] a,
                       input logic ci, output logic [31:0] r, output logic c);
    int n;
    n = int'(a);
    r = op;
    c = ci;
    case (ty)
      3'd0: for (int i = 0; i < n; i++) begin c = r[31]; r = {r[30:0], 1'b0}; end
      3'd1: for (int i = 0; i < n; i++) begin c = r[0];  r = {1'b0, r[31:1]}; end
      3'd2: for (int i = 0; i < n; i++) begin c = r[0];  r = {r[31], r[31:1]}; end
      3'd3: if (n != 0) begin
              for (int i = 0; i < n % 32; i++) r = {r[0], r[31:1]};
              c = r[31];
            end
      3'd4: begin c = op[0]; r = {ci, op[31:1]}; end
      default: ;
    endcase
  endtask

  function automatic string tag_of(input logic [2:0] ty, input logic [7:0] a);
    if (ty > 3'd4) return "R9";
    if (ty == 3'd4) return "R5";
    if (a == 0) return "R6";
    if (a > 32) return (ty == 3'd2) ? "R8" : ((ty == 3'd3) ? "R4" : "R7");
    case (ty)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] gr, input logic [31:0] er,
                       input logic gc, input logic ec);
    checks++;
    if (gr !== er || gc !== ec) begin
      fails++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b", tag, gr, gc, er, ec);
    end
  endtask

  // Called at a negedge: drive one strobe, check at the next negedge.
  task automatic run(input logic [31:0] op, input logic [2:0] ty, input logic [7:0] a,
                     input logic ci, input string tag);
    logic [31:0] er;
    logic        ec;
    model(op, ty, a, ci, er, ec);
    in_valid = 1'b1; operand = op; shift_type = ty; shift_amt = a; carry_in = ci;
    @(negedge clk);
    check(tag, result, er, carry_out, ec);
    check("R10", {31'd0, out_valid}, 32'd1, 1'b0, 1'b0);
    last_r = result;
    last_c = carry_out;
  endtask

  // Idle cycle with changing inputs: outputs must hold (R11).
  task automatic idle(input logic [31:0] op);
    in_valid = 1'b0; operand = op; shift_type = 3'd4; shift_amt = 8'd7; carry_in = ~carry_in;
    @(negedge clk);
    check("R11", result, last_r, carry_out, last_c);
    check("R10", {31'd0, out_valid}, 32'd0, 1'b0, 1'b0);
  endtask

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog: result=%h carry=%b expected result=%h carry=%b", result, carry_out, 32'd0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", result, 32'd0, carry_out, 1'b0);
    check("R12", {31'd0, out_valid}, 32'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    run(32'h8000_0001, 3'd0, 8'd1,   1'b0, "R1");
    run(32'h0000_0001, 3'd0, 8'd32,  1'b0, "R1");
    run(32'h1234_5678, 3'd0, 8'd31,  1'b1, "R1");
    run(32'h8000_0003, 3'd1, 8'd2,   1'b0, "R2");
    run(32'h8000_0000, 3'd1, 8'd32,  1'b0, "R2");
    run(32'h8000_00F0, 3'd2, 8'd4,   1'b0, "R3");
    run(32'h8000_0000, 3'd2, 8'd32,  1'b0, "R3");
    run(32'h7FFF_FFFF, 3'd2, 8'd31,  1'b1, "R3");
    run(32'h0000_0001, 3'd3, 8'd1,   1'b0, "R4");
    run(32'hA5A5_0F0F, 3'd3, 8'd32,  1'b0, "R4");
    run(32'h0000_0010, 3'd3, 8'd36,  1'b0, "R4");
    run(32'h0000_0001, 3'd4, 8'd0,   1'b1, "R5");
    run(32'hFFFF_FFFE, 3'd4, 8'd200, 1'b0, "R5");
    idle(32'hDEAD_BEEF);
    run(32'hCAFE_F00D, 3'd0, 8'd0,   1'b1, "R6");
    run(32'hCAFE_F00D, 3'd2, 8'd0,   1'b0, "R6");
    run(32'hCAFE_F00D, 3'd3, 8'd0,   1'b1, "R6");
    run(32'hFFFF_FFFF, 3'd0, 8'd33,  1'b1, "R7");
    run(32'hFFFF_FFFF, 3'd1, 8'd255, 1'b1, "R7");
    run(32'h8000_0000, 3'd2, 8'd100, 1'b0, "R8");
    run(32'h7FFF_FFFF, 3'd2, 8'd33,  1'b1, "R8");
    run(32'h1357_9BDF, 3'd5, 8'd3,   1'b1, "R9");
    run(32'h1357_9BDF, 3'd7, 8'd40,  1'b0, "R9");
    idle(32'h0);
    idle(32'h5555_5555);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] op;
      logic [2:0]  ty;
      logic [7:0]  a;
      op = $urandom;
      ty = 3'($urandom % 8);
      a  = (k % 3 == 0) ? 8'($urandom % 40) : 8'($urandom);
      run(op, ty, a, 1'($urandom), tag_of(ty, a));
      if (k % 7 == 0) idle($urandom);
    end

    in_valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule